// File: doc/BRIEF.md
# Masked Vector Element ALU

This block executes one element-wise vector addition per instruction. It holds a small file of vector registers, a predicate mask register and an active-length register. An instruction names a destination and two sources. The second source can be swapped for a 32-bit immediate that is broadcast to every element. The unit walks the element indices one per clock.

An element is written only when both of these hold:
- its index is below the active length, where the length is limited to the hardware maximum of 64;
- its mask bit is set.

Every other destination element keeps its old value.

A host loads operands through an element write port and reads results through a combinational element read port. It programs the mask and the length through their own write strobes. Each instruction is framed by a `start` pulse and a one-cycle `done` pulse.

Top module: `vmalu`

## Requirements
- R1: After reset, `busy` and `done` are 0, every vector element reads 0, the mask is all zeros and the active length is 0.
- R2: While idle, `wr_en` writes `wr_data` into element `wr_idx` of register `wr_vreg`. `rd_data` always shows element `rd_idx` of register `rd_vreg` combinationally.
- R3: With `op_scalar`=0, each written destination element becomes `vs1[i] + vs2[i]` modulo 2^32.
- R4: With `op_scalar`=1, each written destination element becomes `vs1[i] + imm` modulo 2^32.
- R5: A destination element whose mask bit (bit i of the mask for element i) is 0 keeps its previous value.
- R6: A destination element with index i >= min(length, 64) keeps its previous value.
- R7: A programmed length above 64 (the length field is 8 bits) acts as 64.
- R8: Let the start edge be the clock edge that samples `start` while idle, and let L be the effective length. For L >= 1, `busy` is high for L cycles after the start edge. `done` then goes high for exactly one cycle, beginning at the L-th edge after the start edge, and the final write is visible in that cycle.
- R9: With an effective length of 0, `done` pulses in the cycle right after the start edge, `busy` stays 0 and nothing is written.
- R10: While `busy`, both `start` and `wr_en` are ignored.
- R11: The mask and the length are captured at the start edge. Writes to them while `busy` take effect only from the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host element write strobe |
| wr_vreg | input | 2 | Host write register select |
| wr_idx | input | 6 | Host write element index |
| wr_data | input | 32 | Host write data |
| rd_vreg | input | 2 | Read register select |
| rd_idx | input | 6 | Read element index |
| rd_data | output | 32 | Read element data |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 64 | New mask, bit i gates element i |
| len_we | input | 1 | Length register write strobe |
| len_wdata | input | 8 | New active length |
| start | input | 1 | Start an instruction |
| op_scalar | input | 1 | 1: second operand is `imm` |
| vd | input | 2 | Destination register |
| vs1 | input | 2 | First source register |
| vs2 | input | 2 | Second source register |
| imm | input | 32 | Broadcast scalar operand |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a run that is disturbed from outside. The bench drives a new `start`, a host element write, a new mask and a new length in the cycle right after the start edge, while the walk is still in progress. It must then show that the run finishes with its captured mask and limit and its original timing, that the host write was dropped, and that the new mask and length govern the next instruction. A directed sequence creates exactly that collision. Random instructions then cover lengths on both sides of 64, zero length, aliased source and destination registers, and arbitrary masks.

// File: rtl/vmalu_pkg.sv
package vmalu_pkg;

  // Sequencer states
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vm_state_e;

endpackage

// File: rtl/vmalu_vrf.sv
// Vector register file: one write port, NUM_RD combinational read ports.
module vmalu_vrf #(
  parameter int ELEM_W    = 32,
  parameter int MAX_VL    = 64,
  parameter int NUM_VREGS = 4,
  parameter int NUM_RD    = 3,
  parameter int IDX_W     = 6,
  parameter int VREG_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [VREG_W-1:0] wsel_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [ELEM_W-1:0] wdata_i,
  input  logic [VREG_W-1:0] rsel_i  [NUM_RD],
  input  logic [IDX_W-1:0]  ridx_i  [NUM_RD],
  output logic [ELEM_W-1:0] rdata_o [NUM_RD]
);

  logic [ELEM_W-1:0] mem_q [NUM_VREGS][MAX_VL];
  logic [NUM_VREGS-1:0] row_we;

  // Per-register write decode
  genvar r;
  generate
    for (r = 0; r < NUM_VREGS; r++) begin : g_row_dec
      assign row_we[r] = we_i && (wsel_i == VREG_W'(r));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_VREGS; i++) begin
        for (int j = 0; j < MAX_VL; j++) begin
          mem_q[i][j] <= '0;
        end
      end
    end else begin
      for (int i = 0; i < NUM_VREGS; i++) begin
        if (row_we[i]) begin
          mem_q[i][widx_i] <= wdata_i;
        end
      end
    end
  end

  genvar p;
  generate
    for (p = 0; p < NUM_RD; p++) begin : g_rd
      assign rdata_o[p] = mem_q[rsel_i[p]][ridx_i[p]];
    end
  endgenerate

endmodule

// File: rtl/vmalu_elem_op.sv
// Element operation: first operand plus either the second operand or the broadcast scalar.
module vmalu_elem_op #(
  parameter int ELEM_W = 32
) (
  input  logic [ELEM_W-1:0] a_i,
  input  logic [ELEM_W-1:0] b_i,
  input  logic [ELEM_W-1:0] imm_i,
  input  logic              scalar_i,
  output logic [ELEM_W-1:0] res_o
);

  logic [ELEM_W-1:0] rhs;

  always_comb begin
    rhs   = scalar_i ? imm_i : b_i;
    res_o = a_i + rhs; // wraps at ELEM_W bits
  end

endmodule

// File: rtl/vmalu_ctrl.sv
// Sequencer: captures an instruction, clamps the length, walks the element indices.
module vmalu_ctrl
  import vmalu_pkg::*;
#(
  parameter int ELEM_W = 32,
  parameter int MAX_VL = 64,
  parameter int LEN_W  = 8,   // must be at least IDX_W+1
  parameter int IDX_W  = 6,
  parameter int VREG_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [MAX_VL-1:0] mask_i,
  input  logic              scalar_i,
  input  logic [VREG_W-1:0] vd_i,
  input  logic [VREG_W-1:0] vs1_i,
  input  logic [VREG_W-1:0] vs2_i,
  input  logic [ELEM_W-1:0] imm_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ex_we_o,
  output logic [IDX_W-1:0]  ex_idx_o,
  output logic [IDX_W-1:0]  last_o,
  output logic [MAX_VL-1:0] mask_o,
  output logic [VREG_W-1:0] vd_o,
  output logic [VREG_W-1:0] vs1_o,
  output logic [VREG_W-1:0] vs2_o,
  output logic              scalar_o,
  output logic [ELEM_W-1:0] imm_o
);

  localparam int CNT_W = IDX_W + 1;

  vm_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [IDX_W-1:0]  last_q, last_d;
  logic              done_q, done_d;
  logic [MAX_VL-1:0] mask_q;
  logic [VREG_W-1:0] vd_q, vs1_q, vs2_q;
  logic              scalar_q;
  logic [ELEM_W-1:0] imm_q;

  logic [CNT_W-1:0]  eff_len;
  logic [CNT_W-1:0]  eff_m1;
  logic              accept;

  // Effective length: programmed length limited to the hardware maximum
  always_comb begin
    if (len_i > LEN_W'(MAX_VL)) begin
      eff_len = CNT_W'(MAX_VL);
    end else begin
      eff_len = len_i[CNT_W-1:0];
    end
    eff_m1 = eff_len - CNT_W'(1);
  end

  assign accept = start_i && (state_q == ST_IDLE);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    last_d  = last_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (eff_len == '0) begin
            done_d = 1'b1;
          end else begin
            state_d = ST_RUN;
            idx_d   = '0;
            last_d  = eff_m1[IDX_W-1:0];
          end
        end
      end
      ST_RUN: begin
        if (idx_q == last_q) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Sequencer registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      done_q  <= done_d;
    end
  end

  // Instruction capture, enabled only on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      vd_q     <= '0;
      vs1_q    <= '0;
      vs2_q    <= '0;
      scalar_q <= 1'b0;
      imm_q    <= '0;
    end else if (accept) begin
      mask_q   <= mask_i;
      vd_q     <= vd_i;
      vs1_q    <= vs1_i;
      vs2_q    <= vs2_i;
      scalar_q <= scalar_i;
      imm_q    <= imm_i;
    end
  end

  assign busy_o   = (state_q == ST_RUN);
  assign done_o   = done_q;
  assign ex_we_o  = (state_q == ST_RUN) && mask_q[idx_q];
  assign ex_idx_o = idx_q;
  assign last_o   = last_q;
  assign mask_o   = mask_q;
  assign vd_o     = vd_q;
  assign vs1_o    = vs1_q;
  assign vs2_o    = vs2_q;
  assign scalar_o = scalar_q;
  assign imm_o    = imm_q;

endmodule

// File: rtl/vmalu.sv
// Masked vector element ALU, top level.
module vmalu #(
  parameter int ELEM_W    = 32,
  parameter int MAX_VL    = 64,
  parameter int NUM_VREGS = 4,
  parameter int LEN_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [$clog2(NUM_VREGS)-1:0] wr_vreg,
  input  logic [$clog2(MAX_VL)-1:0]    wr_idx,
  input  logic [ELEM_W-1:0]            wr_data,
  input  logic [$clog2(NUM_VREGS)-1:0] rd_vreg,
  input  logic [$clog2(MAX_VL)-1:0]    rd_idx,
  output logic [ELEM_W-1:0]            rd_data,
  input  logic                         mask_we,
  input  logic [MAX_VL-1:0]            mask_wdata,
  input  logic                         len_we,
  input  logic [LEN_W-1:0]             len_wdata,
  input  logic                         start,
  input  logic                         op_scalar,
  input  logic [$clog2(NUM_VREGS)-1:0] vd,
  input  logic [$clog2(NUM_VREGS)-1:0] vs1,
  input  logic [$clog2(NUM_VREGS)-1:0] vs2,
  input  logic [ELEM_W-1:0]            imm,
  output logic                         busy,
  output logic                         done
);

  localparam int IDX_W  = $clog2(MAX_VL);
  localparam int VREG_W = $clog2(NUM_VREGS);
  localparam int NUM_RD = 3;

  // Architectural mask and length registers
  logic [MAX_VL-1:0] mask_q, mask_d;
  logic [LEN_W-1:0]  len_q, len_d;

  always_comb begin
    mask_d = mask_we ? mask_wdata : mask_q;
    len_d  = len_we  ? len_wdata  : len_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      len_q  <= '0;
    end else begin
      mask_q <= mask_d;
      len_q  <= len_d;
    end
  end

  // Sequencer
  logic              ex_we;
  logic [IDX_W-1:0]  ex_idx;
  logic [IDX_W-1:0]  last_idx;
  logic [MAX_VL-1:0] mask_snap;
  logic [VREG_W-1:0] cur_vd, cur_vs1, cur_vs2;
  logic              cur_scalar;
  logic [ELEM_W-1:0] cur_imm;

  vmalu_ctrl #(
    .ELEM_W (ELEM_W),
    .MAX_VL (MAX_VL),
    .LEN_W  (LEN_W),
    .IDX_W  (IDX_W),
    .VREG_W (VREG_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .len_i    (len_q),
    .mask_i   (mask_q),
    .scalar_i (op_scalar),
    .vd_i     (vd),
    .vs1_i    (vs1),
    .vs2_i    (vs2),
    .imm_i    (imm),
    .busy_o   (busy),
    .done_o   (done),
    .ex_we_o  (ex_we),
    .ex_idx_o (ex_idx),
    .last_o   (last_idx),
    .mask_o   (mask_snap),
    .vd_o     (cur_vd),
    .vs1_o    (cur_vs1),
    .vs2_o    (cur_vs2),
    .scalar_o (cur_scalar),
    .imm_o    (cur_imm)
  );

  // Register file: port 0/1 feed the datapath, port 2 serves the host
  logic [VREG_W-1:0] rsel  [NUM_RD];
  logic [IDX_W-1:0]  ridx  [NUM_RD];
  logic [ELEM_W-1:0] rdata [NUM_RD];
  logic              vrf_we;
  logic [VREG_W-1:0] vrf_wsel;
  logic [IDX_W-1:0]  vrf_widx;
  logic [ELEM_W-1:0] vrf_wdata;
  logic [ELEM_W-1:0] elem_res;

  always_comb begin
    rsel[0] = cur_vs1;
    ridx[0] = ex_idx;
    rsel[1] = cur_vs2;
    ridx[1] = ex_idx;
    rsel[2] = rd_vreg;
    ridx[2] = rd_idx;
  end

  // Write port: the running instruction owns it, host writes only while idle
  always_comb begin
    if (busy) begin
      vrf_we    = ex_we;
      vrf_wsel  = cur_vd;
      vrf_widx  = ex_idx;
      vrf_wdata = elem_res;
    end else begin
      vrf_we    = wr_en;
      vrf_wsel  = wr_vreg;
      vrf_widx  = wr_idx;
      vrf_wdata = wr_data;
    end
  end

  vmalu_vrf #(
    .ELEM_W    (ELEM_W),
    .MAX_VL    (MAX_VL),
    .NUM_VREGS (NUM_VREGS),
    .NUM_RD    (NUM_RD),
    .IDX_W     (IDX_W),
    .VREG_W    (VREG_W)
  ) u_vrf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (vrf_we),
    .wsel_i  (vrf_wsel),
    .widx_i  (vrf_widx),
    .wdata_i (vrf_wdata),
    .rsel_i  (rsel),
    .ridx_i  (ridx),
    .rdata_o (rdata)
  );

  vmalu_elem_op #(
    .ELEM_W (ELEM_W)
  ) u_op (
    .a_i      (rdata[0]),
    .b_i      (rdata[1]),
    .imm_i    (cur_imm),
    .scalar_i (cur_scalar),
    .res_o    (elem_res)
  );

  assign rd_data = rdata[2];

endmodule

// File: rtl/vmalu_chk.sv
// Protocol and sequencing checks, attached to the top by bind.
module vmalu_chk #(
  parameter int MAX_VL = 64,
  parameter int IDX_W  = 6,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [LEN_W-1:0]  len_q,
  input logic [IDX_W-1:0]  ex_idx,
  input logic [IDX_W-1:0]  last_idx,
  input logic [MAX_VL-1:0] mask_snap
);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_idx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> ex_idx == IDX_W'($past(ex_idx) + 1'b1));

  p_start_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (len_q != '0) |=> busy && !done);

  p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (len_q == '0) |=> done && !busy);

  p_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (len_q > LEN_W'(MAX_VL)) |=> busy && (last_idx == IDX_W'(MAX_VL - 1)));

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> busy || done);

  p_snap_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mask_snap) && $stable(last_idx));

endmodule

bind vmalu vmalu_chk #(
  .MAX_VL (MAX_VL),
  .IDX_W  (IDX_W),
  .LEN_W  (LEN_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .len_q     (len_q),
  .ex_idx    (ex_idx),
  .last_idx  (last_idx),
  .mask_snap (mask_snap)
);

// File: tb/vmalu_bench.sv
module vmalu_bench;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_vreg;
  logic [5:0]  wr_idx;
  logic [31:0] wr_data;
  logic [1:0]  rd_vreg;
  logic [5:0]  rd_idx;
  logic [31:0] rd_data;
  logic        mask_we;
  logic [63:0] mask_wdata;
  logic        len_we;
  logic [7:0]  len_wdata;
  logic        start;
  logic        op_scalar;
  logic [1:0]  vd, vs1, vs2;
  logic [31:0] imm;
  logic        busy, done;

  vmalu u_vmalu (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_vreg(wr_vreg), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_vreg(rd_vreg), .rd_idx(rd_idx), .rd_data(rd_data),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .len_we(len_we), .len_wdata(len_wdata),
    .start(start), .op_scalar(op_scalar),
    .vd(vd), .vs1(vs1), .vs2(vs2), .imm(imm),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] model [4][64];
  logic [63:0] m_mask;
  int          m_len;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int eff_len(input int l);
    return (l > 64) ? 64 : l;
  endfunction

  function automatic logic [31:0] elem_sum(input logic [31:0] a, input logic [31:0] b);
    return a + b;
  endfunction

  task automatic host_wr(input int r, input int i, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_vreg = 2'(r); wr_idx = 6'(i); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model[r][i] = d;
  endtask

  task automatic set_mask_len(input logic [63:0] m, input int l);
    @(negedge clk);
    mask_we = 1'b1; mask_wdata = m; len_we = 1'b1; len_wdata = 8'(l);
    @(negedge clk);
    mask_we = 1'b0; len_we = 1'b0;
    m_mask = m; m_len = l;
  endtask

  task automatic readback(input string req);
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 64; i++) begin
        rd_vreg = 2'(r); rd_idx = 6'(i);
        #0.5;
        chk(req, rd_data, model[r][i]);
      end
    end
  endtask

  // Issue one instruction, compare timing and the whole register file.
  task automatic run(input int d, input int s1, input int s2, input bit sc,
                     input logic [31:0] im, input bit poke, input string req);
    logic [31:0] src1 [64];
    logic [31:0] src2 [64];
    int l;
    int n;
    l = eff_len(m_len);
    for (int i = 0; i < 64; i++) begin
      src1[i] = model[s1][i];
      src2[i] = model[s2][i];
    end
    for (int i = 0; i < l; i++) begin
      if (m_mask[i]) model[d][i] = elem_sum(src1[i], sc ? im : src2[i]);
    end
    @(negedge clk);
    start = 1'b1; vd = 2'(d); vs1 = 2'(s1); vs2 = 2'(s2); op_scalar = sc; imm = im;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    if (poke) begin
      // R10 / R11: disturbances in the first cycle of the run
      start = 1'b1; vd = 2'((d + 1) % 4); op_scalar = 1'b1; imm = 32'h1111_0000;
      wr_en = 1'b1; wr_vreg = 2'((d + 2) % 4); wr_idx = 6'd5; wr_data = 32'hDEAD_BEEF;
      mask_we = 1'b1; mask_wdata = ~m_mask;
      len_we = 1'b1; len_wdata = 8'd3;
    end
    while (!done && n < 300) begin
      @(negedge clk);
      if (poke && n == 0) begin
        start = 1'b0; wr_en = 1'b0; mask_we = 1'b0; len_we = 1'b0;
      end
      n++;
    end
    if (poke) begin
      m_mask = ~m_mask;
      m_len = 3;
    end
    chk({req, " done latency R8"}, 32'(n), 32'(l));
    chk({req, " busy clear at done R8"}, {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk({req, " done single cycle R8"}, {31'd0, done}, 32'd0);
    readback(req);
  endtask

  // Watchdog
  initial begin
    #(200000 * 4);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    wr_en = 0; wr_vreg = 0; wr_idx = 0; wr_data = 0;
    rd_vreg = 0; rd_idx = 0;
    mask_we = 0; mask_wdata = 0; len_we = 0; len_wdata = 0;
    start = 0; op_scalar = 0; vd = 0; vs1 = 0; vs2 = 0; imm = 0;
    for (int r = 0; r < 4; r++) for (int i = 0; i < 64; i++) model[r][i] = 32'd0;
    m_mask = '0; m_len = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    readback("R1 element");
    // R1: length 0 after reset -> a start completes at once
    run(0, 1, 2, 1'b0, 32'd0, 1'b0, "R1 R9 reset length");

    // R2: host loads
    for (int r = 0; r < 4; r++)
      for (int i = 0; i < 64; i++) host_wr(r, i, $urandom);
    readback("R2 host write");

    // R3: full length, all lanes
    set_mask_len({64{1'b1}}, 64);
    run(2, 0, 1, 1'b0, 32'd0, 1'b0, "R3 full vector add");

    // R3: wrap modulo 2^32
    host_wr(0, 0, 32'hFFFF_FFFF);
    host_wr(1, 0, 32'h0000_0002);
    set_mask_len(64'h1, 1);
    run(3, 0, 1, 1'b0, 32'd0, 1'b0, "R3 wrap");
    rd_vreg = 2'd3; rd_idx = 6'd0; #0.5;
    chk("R3 wrap value", rd_data, 32'h0000_0001);

    // R4 R5 R6: scalar +1, partial mask, short length
    set_mask_len(64'hA5A5_A5A5_A5A5_0F0F, 10);
    run(1, 1, 0, 1'b1, 32'd1, 1'b0, "R4 R5 R6 scalar add");

    // R7: length above the maximum
    set_mask_len({$urandom, $urandom}, 200);
    run(0, 2, 3, 1'b0, 32'd0, 1'b0, "R7 clamp");

    // R9: zero length
    set_mask_len({64{1'b1}}, 0);
    run(2, 0, 1, 1'b1, 32'd7, 1'b0, "R9 zero length");

    // R5: mask empty, nothing written but timing kept
    set_mask_len(64'd0, 20);
    run(3, 0, 1, 1'b0, 32'd0, 1'b0, "R5 empty mask");

    // R10 R11: collisions while busy
    set_mask_len(64'hF0F0_3333_CCCC_0F0F, 30);
    run(1, 2, 3, 1'b0, 32'd0, 1'b1, "R10 R11 busy pokes");
    // the new mask and length of 3 govern this one
    run(0, 1, 2, 1'b1, 32'h8000_0000, 1'b0, "R11 next instruction");

    // random instructions
    for (int k = 0; k < 24; k++) begin
      set_mask_len({$urandom, $urandom}, int'($urandom_range(0, 100)));
      run(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
          1'($urandom_range(0, 1)), $urandom, 1'b0, "R3 R4 R5 R6 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule